// File: doc/BRIEF.md
# Pipelined Multi-Port Read RAM

A byte-addressed memory held internally as 16-bit words and shared by several video read channels and one 8-bit host port. Every channel presents a byte address on every clock. A slot counter gives one channel the read port in each cycle, so a full round takes as many cycles as there are channels. The word that comes back two clocks later is byte-aligned: the addressed byte sits in the low lane and its partner byte from the same word sits in the high lane. The aligned word, a tag supplied with the request and a round-end marker then travel down one shared shift pipe. When a round's last request reaches a set depth, every channel loads its result and its tag from its own fixed tap, all in the same cycle.

The host port reads and writes single bytes. A write changes only the addressed byte lane of its word. A read returns the addressed byte two clocks after the request. Channel addresses are normally driven by address generators and tags by pixel coordinates. Neither of those sits inside this block.

Top module: `mp_read_ram`

## Requirements
- R1: While reset is held and in the cycle after it, `rd_strobe` and `host_rvalid` are 0 and every bit of `rd_data`, `rd_tag` and `host_rdata` is 0.
- R2: Count clock edges from the first rising edge that samples reset low as edge 0. Edge e samples the address and tag of channel e mod NUM_CH.
- R3: In every channel result, bits [7:0] hold the byte stored at the byte address that channel presented.
- R4: In every channel result, bits [15:8] hold the byte at the same address with bit 0 inverted. An even address therefore gives its word unchanged, and an odd address gives the word with its two bytes swapped. Address 0 and the highest address follow the same rule.
- R5: Each channel's `rd_tag` equals the tag that was presented together with the address of the result shown in the same cycle.
- R6: `rd_strobe` is high for one cycle after each edge m where m is at least NUM_CH+2+PIPE_SLACK and (m - NUM_CH - 2 - PIPE_SLACK) mod NUM_CH is 0, and it is low after every other edge. All channel data and tags change only after edges where `rd_strobe` goes high.
- R7: A host write with `host_en`=1 and `host_we`=1 stores `host_wdata` in the byte at `host_addr` and leaves the other byte of that 16-bit word unchanged.
- R8: A host read with `host_en`=1 and `host_we`=0, sampled at edge e, sets `host_rvalid` to 1 for exactly the cycle after edge e+1, with `host_rdata` holding the addressed byte.
- R9: A channel read or host read sampled at the same edge as a host write to the same byte returns the newly written byte. A read sampled one edge before that write returns the old byte.
- R10: While `host_en`=0, `host_we` and `host_wdata` change no stored byte and `host_rvalid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | NUM_CH*ADDR_W | Byte address per channel, channel k at bits [k*ADDR_W +: ADDR_W] |
| rd_tag_in | input | NUM_CH*TAG_W | Request tag per channel, same packing |
| rd_data | output | NUM_CH*16 | Aligned result per channel, channel k at bits [k*16 +: 16] |
| rd_tag | output | NUM_CH*TAG_W | Tag matching each channel result |
| rd_strobe | output | 1 | One-cycle pulse marking a new set of channel results |
| host_en | input | 1 | Host access enable |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_rvalid | output | 1 | Host read result valid |

## Verification
A host write and a channel or host read of the same word can land on the same clock edge. This is the case where read-before-write ordering decides what comes back. To provoke it, the bench pins every channel to the two bytes of one word while the host rewrites those bytes on every cycle. It also issues host reads immediately before writes to the same byte. The reference model settles each such collision by the rule in R9: a read sampled at an edge sees the writes sampled at that edge and earlier, and none sampled later. Every channel result, tag, strobe and host read is then compared against the model.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    // Cycles from a word address entering storage to its word leaving it.
    localparam int RD_LAT = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Put the addressed byte in the low lane and its partner in the high lane.
    function automatic word_t align_word(input word_t w, input logic odd);
        return odd ? {w[7:0], w[15:8]} : w;
    endfunction

    function automatic byte_t pick_lane(input word_t w, input logic hi);
        return hi ? w[15:8] : w[7:0];
    endfunction

endpackage

// File: rtl/mpr_slot_mux.sv
module mpr_slot_mux #(
    parameter int NUM_CH = 5,
    parameter int ADDR_W = 10,
    parameter int TAG_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH*ADDR_W-1:0] ch_addr,
    input  logic [NUM_CH*TAG_W-1:0]  ch_tag,
    output logic [ADDR_W-1:0]        req_addr,
    output logic [TAG_W-1:0]         req_tag,
    output logic                     req_last
);
    localparam int SW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_CH - 1);

    logic [SW-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst)                    slot <= '0;
        else if (slot == LAST_SLOT) slot <= '0;
        else                        slot <= slot + 1'b1;
    end

    always_comb begin
        req_addr = '0;
        req_tag  = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (slot == SW'(k)) begin
                req_addr = ch_addr[k*ADDR_W +: ADDR_W];
                req_tag  = ch_tag[k*TAG_W +: TAG_W];
            end
        end
    end

    assign req_last = (slot == LAST_SLOT);

    // R2: the rotation closes after the last channel
    a_r2_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (slot == LAST_SLOT) |=> (slot == '0));
    // R2: otherwise the next channel follows
    a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
        (slot != LAST_SLOT) |=> (slot == $past(slot) + SW'(1)));

endmodule

// File: rtl/mpr_word_store.sv
module mpr_word_store
    import mpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-2:0] vid_waddr,
    output word_t             vid_word,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  byte_t             host_wdata,
    output byte_t             host_rdata,
    output logic              host_rvalid
);
    localparam int WORDS = 2 ** (ADDR_W - 1);

    word_t             mem [WORDS];
    logic [ADDR_W-2:0] vaddr_q;
    logic [ADDR_W-1:0] haddr_q;
    logic              hreq_q;

    // Host byte write: one lane of the addressed word.
    always_ff @(posedge clk) begin
        if (host_en && host_we) begin
            if (host_addr[0]) mem[host_addr[ADDR_W-1:1]][15:8] <= host_wdata;
            else              mem[host_addr[ADDR_W-1:1]][7:0]  <= host_wdata;
        end
    end

    // Video read: address register then data register (RD_LAT = 2).
    always_ff @(posedge clk) begin
        vaddr_q  <= vid_waddr;
        vid_word <= mem[vaddr_q];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            haddr_q     <= '0;
            hreq_q      <= 1'b0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            haddr_q     <= host_addr;
            hreq_q      <= host_en && !host_we;
            host_rvalid <= hreq_q;
            if (hreq_q)
                host_rdata <= pick_lane(mem[haddr_q[ADDR_W-1:1]], haddr_q[0]);
        end
    end

    // R8: a valid host result always traces back to a read two edges earlier
    a_r8_rvalid_origin: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> $past(host_en && !host_we, 2));

endmodule

// File: rtl/mpr_lane_align.sv
module mpr_lane_align
    import mpr_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_lsb,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_last,
    input  word_t            mem_word,
    output word_t            al_word,
    output logic [TAG_W-1:0] al_tag,
    output logic             al_last
);
    typedef struct packed {
        logic             last;
        logic             lsb;
        logic [TAG_W-1:0] tag;
    } side_t;

    // Side information goes through as many flops as the storage read path.
    side_t stg [RD_LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RD_LAT; i++) stg[i] <= '0;
        end else begin
            stg[0] <= '{last: req_last, lsb: req_lsb, tag: req_tag};
            for (int i = 1; i < RD_LAT; i++) stg[i] <= stg[i-1];
        end
    end

    assign al_word = align_word(mem_word, stg[RD_LAT-1].lsb);
    assign al_tag  = stg[RD_LAT-1].tag;
    assign al_last = stg[RD_LAT-1].last;

endmodule

// File: rtl/mpr_tap_pipe.sv
module mpr_tap_pipe
    import mpr_pkg::*;
#(
    parameter int NUM_CH     = 5,
    parameter int TAG_W      = 12,
    parameter int PIPE_SLACK = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  word_t                    in_word,
    input  logic [TAG_W-1:0]         in_tag,
    input  logic                     in_last,
    output logic [NUM_CH*WORD_W-1:0] rd_data,
    output logic [NUM_CH*TAG_W-1:0]  rd_tag,
    output logic                     rd_strobe
);
    localparam int DEPTH = NUM_CH + PIPE_SLACK;

    typedef struct packed {
        logic             last;
        logic [TAG_W-1:0] tag;
        word_t            word;
    } ent_t;

    ent_t pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
            rd_strobe <= 1'b0;
        end else begin
            pipe[0] <= '{last: in_last, tag: in_tag, word: in_word};
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
            rd_strobe <= pipe[PIPE_SLACK].last;
        end
    end

    // A round's last request sits at PIPE_SLACK; channel k sits NUM_CH-1-k further on.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam int TAP = PIPE_SLACK + NUM_CH - 1 - k;
        word_t            q_word;
        logic [TAG_W-1:0] q_tag;

        always_ff @(posedge clk) begin
            if (rst) begin
                q_word <= '0;
                q_tag  <= '0;
            end else if (pipe[PIPE_SLACK].last) begin
                q_word <= pipe[TAP].word;
                q_tag  <= pipe[TAP].tag;
            end
        end

        assign rd_data[k*WORD_W +: WORD_W] = q_word;
        assign rd_tag[k*TAG_W +: TAG_W]    = q_tag;
    end

    if (NUM_CH > 1) begin : g_pulse_chk
        // R6: round-end markers are NUM_CH apart, so the strobe never lasts two cycles
        a_r6_single_strobe: assert property (@(posedge clk) disable iff (rst)
            rd_strobe |=> !rd_strobe);
    end

    // R6: results and tags move only with the strobe
    a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |-> ($stable(rd_data) && $stable(rd_tag)));

endmodule

// File: rtl/mp_read_ram.sv
module mp_read_ram
    import mpr_pkg::*;
#(
    parameter int NUM_CH     = 5,
    parameter int ADDR_W     = 10,
    parameter int TAG_W      = 12,
    parameter int PIPE_SLACK = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH*ADDR_W-1:0] rd_addr,
    input  logic [NUM_CH*TAG_W-1:0]  rd_tag_in,
    output logic [NUM_CH*16-1:0]     rd_data,
    output logic [NUM_CH*TAG_W-1:0]  rd_tag,
    output logic                     rd_strobe,
    input  logic                     host_en,
    input  logic                     host_we,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata,
    output logic                     host_rvalid
);
    logic [ADDR_W-1:0] req_addr;
    logic [TAG_W-1:0]  req_tag;
    logic              req_last;
    word_t             mem_word;
    word_t             al_word;
    logic [TAG_W-1:0]  al_tag;
    logic              al_last;

    mpr_slot_mux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .ch_addr  (rd_addr),
        .ch_tag   (rd_tag_in),
        .req_addr (req_addr),
        .req_tag  (req_tag),
        .req_last (req_last)
    );

    mpr_word_store #(.ADDR_W(ADDR_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .vid_waddr   (req_addr[ADDR_W-1:1]),
        .vid_word    (mem_word),
        .host_en     (host_en),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    mpr_lane_align #(.TAG_W(TAG_W)) u_align (
        .clk      (clk),
        .rst      (rst),
        .req_lsb  (req_addr[0]),
        .req_tag  (req_tag),
        .req_last (req_last),
        .mem_word (mem_word),
        .al_word  (al_word),
        .al_tag   (al_tag),
        .al_last  (al_last)
    );

    mpr_tap_pipe #(.NUM_CH(NUM_CH), .TAG_W(TAG_W), .PIPE_SLACK(PIPE_SLACK)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_word   (al_word),
        .in_tag    (al_tag),
        .in_last   (al_last),
        .rd_data   (rd_data),
        .rd_tag    (rd_tag),
        .rd_strobe (rd_strobe)
    );

endmodule

// File: tb/mp_read_ram_tb.sv
`timescale 1ns/1ps
module mp_read_ram_tb;

    localparam int NCH   = 5;
    localparam int AW    = 10;
    localparam int TW    = 12;
    localparam int SLACK = 5;
    localparam int BYTES = 2 ** AW;
    localparam int STB0  = NCH + 2 + SLACK;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NCH*AW-1:0]   rd_addr   = '0;
    logic [NCH*TW-1:0]   rd_tag_in = '0;
    logic [NCH*16-1:0]   rd_data;
    logic [NCH*TW-1:0]   rd_tag;
    logic                rd_strobe;
    logic                host_en    = 1'b0;
    logic                host_we    = 1'b0;
    logic [AW-1:0]       host_addr  = '0;
    logic [7:0]          host_wdata = '0;
    logic [7:0]          host_rdata;
    logic                host_rvalid;

    always #10 clk = ~clk;

    mp_read_ram #(.NUM_CH(NCH), .ADDR_W(AW), .TAG_W(TW), .PIPE_SLACK(SLACK)) u_dut (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_tag_in(rd_tag_in),
        .rd_data(rd_data), .rd_tag(rd_tag), .rd_strobe(rd_strobe),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    typedef struct {
        logic [7:0]    lo;
        logic [7:0]    hi;
        logic [TW-1:0] tag;
        bit            ok;
    } vexp_t;

    typedef struct {
        logic [7:0] val;
        bit         ok;
        int         due;
    } hexp_t;

    logic [7:0] mm [BYTES];
    bit         kn [BYTES];
    vexp_t      vq [NCH][$];
    hexp_t      hq [$];
    int         e = 0;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    string      focus = "";

    task automatic check(input bit good, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s at edge %0d: actual %0h expected %0h", req, focus, e, act, exp);
        end
    endtask

    // Reference update for edge e, using the inputs presented before it.
    task automatic model_edge();
        int s;
        logic [AW-1:0] a;
        vexp_t v;
        hexp_t h;
        if (host_en && host_we) begin
            mm[host_addr] = host_wdata;
            kn[host_addr] = 1'b1;
        end
        s = e % NCH;
        a = rd_addr[s*AW +: AW];
        v.lo  = mm[a];
        v.hi  = mm[a ^ AW'(1)];
        v.ok  = kn[a] && kn[a ^ AW'(1)];
        v.tag = rd_tag_in[s*TW +: TW];
        vq[s].push_back(v);
        if (host_en && !host_we) begin
            h.val = mm[host_addr];
            h.ok  = kn[host_addr];
            h.due = e + 1;
            hq.push_back(h);
        end
    endtask

    task automatic check_edge();
        bit sexp;
        bit hexp;
        vexp_t v;
        hexp_t h;
        sexp = (e >= STB0) && (((e - STB0) % NCH) == 0);
        check(rd_strobe == sexp, "R6 strobe", 32'(rd_strobe), 32'(sexp));
        if (sexp) begin
            for (int k = 0; k < NCH; k++) begin
                if (vq[k].size() == 0) begin
                    check(1'b0, "R2 missing request", 0, 1);
                end else begin
                    v = vq[k].pop_front();
                    if (v.ok) begin
                        check(rd_data[k*16 +: 8] == v.lo, "R2 R3 low lane",
                              32'(rd_data[k*16 +: 8]), 32'(v.lo));
                        check(rd_data[k*16+8 +: 8] == v.hi, "R4 high lane",
                              32'(rd_data[k*16+8 +: 8]), 32'(v.hi));
                    end
                    check(rd_tag[k*TW +: TW] == v.tag, "R5 tag",
                          32'(rd_tag[k*TW +: TW]), 32'(v.tag));
                end
            end
        end
        hexp = (hq.size() > 0) && (hq[0].due == e);
        check(host_rvalid == hexp, "R8 R10 rvalid", 32'(host_rvalid), 32'(hexp));
        if (hexp) begin
            h = hq.pop_front();
            if (h.ok)
                check(host_rdata == h.val, "R7 R8 host byte", 32'(host_rdata), 32'(h.val));
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_edge();
        e++;
    endtask

    task automatic rand_channels();
        for (int k = 0; k < NCH; k++) begin
            rd_addr[k*AW +: AW]   = AW'($urandom);
            rd_tag_in[k*TW +: TW] = TW'($urandom);
        end
    endtask

    task automatic host_idle();
        host_en = 1'b0; host_we = 1'($urandom); host_wdata = 8'($urandom);
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [7:0] d);
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    endtask

    task automatic host_read(input logic [AW-1:0] a);
        host_en = 1'b1; host_we = 1'b0; host_addr = a;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < BYTES; i++) begin mm[i] = '0; kn[i] = 1'b0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check(rd_strobe == 1'b0, "R1 strobe", 32'(rd_strobe), 0);
        check(host_rvalid == 1'b0, "R1 rvalid", 32'(host_rvalid), 0);
        check(rd_data == '0, "R1 data", rd_data[31:0], 0);
        check(rd_tag == '0, "R1 tag", rd_tag[31:0], 0);
        check(host_rdata == '0, "R1 host data", 32'(host_rdata), 0);
        rst = 1'b0;

        // Fill every byte through the host while channels read at random.
        focus = "fill";
        for (int i = 0; i < BYTES; i++) begin
            rand_channels();
            host_write(AW'(i), 8'($urandom));
            cycle();
        end

        // Mixed random traffic.
        focus = "R2 random";
        for (int i = 0; i < 3000; i++) begin
            rand_channels();
            case ($urandom % 3)
                0: host_write(AW'($urandom), 8'($urandom));
                1: host_read(AW'($urandom));
                default: host_idle();
            endcase
            cycle();
        end

        // Boundary addresses, odd and even.
        focus = "R4 edges";
        for (int i = 0; i < 60; i++) begin
            rd_addr[0*AW +: AW] = '0;
            rd_addr[1*AW +: AW] = AW'(1);
            rd_addr[2*AW +: AW] = AW'(BYTES - 2);
            rd_addr[3*AW +: AW] = AW'(BYTES - 1);
            rd_addr[4*AW +: AW] = AW'(i);
            rd_tag_in = (NCH*TW)'({$urandom, $urandom});
            host_idle();
            cycle();
        end

        // Collisions: every channel on one word, host rewrites it each cycle.
        focus = "R9 collide";
        for (int i = 0; i < 80; i++) begin
            for (int k = 0; k < NCH; k++) rd_addr[k*AW +: AW] = AW'(300 + (k % 2));
            rd_tag_in = (NCH*TW)'({$urandom, $urandom});
            host_write(AW'(300 + (i % 2)), 8'($urandom));
            cycle();
        end
        for (int i = 0; i < 20; i++) begin
            host_read(AW'(300)); cycle();
            host_write(AW'(300), 8'($urandom)); cycle();
            host_read(AW'(300)); cycle();
        end

        // Byte-lane isolation.
        focus = "R7 lane";
        for (int i = 0; i < 16; i++) begin
            rand_channels();
            for (int k = 0; k < NCH; k++) rd_addr[k*AW +: AW] = AW'(400 + 2*i + (k % 2));
            host_write(AW'(401 + 2*i), 8'($urandom)); cycle();
            host_read(AW'(400 + 2*i)); cycle();
            host_read(AW'(401 + 2*i)); cycle();
        end

        // Disabled host: writes must not land.
        focus = "R10 disabled";
        for (int i = 0; i < 32; i++) begin
            rand_channels();
            host_en = 1'b0; host_we = 1'b1;
            host_addr = AW'(600 + i); host_wdata = ~mm[600 + i];
            cycle();
        end
        for (int i = 0; i < 32; i++) begin
            rand_channels();
            for (int k = 0; k < NCH; k++) rd_addr[k*AW +: AW] = AW'(600 + i);
            host_read(AW'(600 + i));
            cycle();
        end

        focus = "drain";
        host_idle();
        for (int i = 0; i < 40; i++) cycle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule